// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port Controller

This block manages a byte-wide group of general-purpose pins. A small register bus sets a direction byte and an output latch byte. For each pin the block produces an output enable and an output value for a tri-state pad, and it takes the level the pad sees back in. Any pin can be handed to an on-chip peripheral through a per-pin override enable and value. The override wins over the direction setting, and the pin level stays readable while the peripheral drives it.

Pad levels are brought into the clock domain through a two-stage synchronizer. The synchronized level feeds three places: the data-register read path, the interrupt-level outputs and the peripheral-input outputs. Interrupt levels are always live. Peripheral inputs are forced low while the stop-mode input is high, so that floating pads cannot toggle logic that is parked. Stop-mode clocking, edge detection and the pad cell are outside the block.

The block has no state machine and no states. It is a set of registers with combinational drive and read paths.

Top module: `gpx_port`

## Requirements
- R1: After reset the direction byte and the output latch are 0. pad_oe reads 0x00, pad_out reads 0x00, and a read of offset 1 returns 0x00.
- R2: A pin whose direction bit is 1 and whose peripheral enable is 0 has its pad_oe bit at 1, and its pad_out bit equals its latch bit.
- R3: A pin whose direction bit is 0 and whose peripheral enable is 0 has its pad_oe bit at 0 and its pad_out bit at 0. Every pin with pad_oe at 0 shows pad_out at 0.
- R4: A write to offset 0 updates the latch even while the pin is an input. The new value appears on pad_out in the cycle after the write for pins that are outputs, or later, once the direction bit is set.
- R5: A read of offset 0 (bus_re high, bus_addr 0) returns the pad level through a two-flop synchronizer. A change on pad_in shows on bus_rdata after the second rising clock edge, and never returns the latch directly.
- R6: A write to offset 1 sets the direction byte, and a read of offset 1 returns the stored byte.
- R7: A pin whose perif_oe bit is 1 has pad_oe at 1 and pad_out equal to its perif_out bit, whatever its direction bit is. A read of offset 0 then shows that driven value.
- R8: perif_in equals the synchronized pad level while stop_mode is 0, and is 0x00 while stop_mode is 1.
- R9: irq_level equals the synchronized pad level at all times, independent of stop_mode, direction and peripheral enables.
- R10: Writes to offsets 2 and 3 change nothing. Reads of those offsets return 0x00, and bus_rdata is 0x00 whenever bus_re is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 data, 1 direction |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_oe | output | 8 | Per-pin driver enable toward the pad |
| pad_out | output | 8 | Per-pin drive value toward the pad |
| pad_in | input | 8 | Level seen at each pad |
| perif_oe | input | 8 | Per-pin peripheral drive takeover |
| perif_out | input | 8 | Peripheral drive value per pin |
| stop_mode | input | 1 | High while the chip is in stop mode |
| perif_in | output | 8 | Synchronized pin level to peripherals, 0 in stop mode |
| irq_level | output | 8 | Synchronized pin level to interrupt logic |

## Verification
A vector table applies mixed configurations: all outputs, all inputs, split nibbles with stop mode, override on top of a partial direction byte, and full override. The expected pad level comes from a pad model, so a read shows the latch, the peripheral value or the external level according to which source owns each pin. The split patterns separate an override that is mistakenly gated by the direction bit from a correct one. Patterns with stop mode set separate the gated peripheral path from the always-live interrupt path. Directed cases then cover latch writes made while a pin is an input, the two-edge synchronizer delay, and accesses to unused offsets.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [1:0] off);
        unique case (off)
            2'd0:    decode_offset = SEL_DATA;
            2'd1:    decode_offset = SEL_DIR;
            default: decode_offset = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= async_in;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_re,
    input  logic [WIDTH-1:0] pin_level,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] bus_rdata
);
    reg_sel_e sel;
    assign sel = decode_offset(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
        end else if (bus_we) begin
            if (sel == SEL_DATA) latch_q <= bus_wdata;
            if (sel == SEL_DIR)  dir_q   <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (sel)
                SEL_DATA: bus_rdata = pin_level;
                SEL_DIR:  bus_rdata = dir_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpx_drive.sv
module gpx_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] perif_oe,
    input  logic [WIDTH-1:0] perif_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            always_comb begin
                if (perif_oe[i]) begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = perif_out[i];
                end else if (dir_q[i]) begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = latch_q[i];
                end else begin
                    pad_oe[i]  = 1'b0;
                    pad_out[i] = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_re,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] perif_oe,
    input  logic [WIDTH-1:0] perif_out,
    input  logic             stop_mode,
    output logic [WIDTH-1:0] perif_in,
    output logic [WIDTH-1:0] irq_level
);
    logic [WIDTH-1:0] level_s;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] latch_q;

    gpx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (level_s)
    );

    gpx_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .pin_level (level_s),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .bus_rdata (bus_rdata)
    );

    gpx_drive #(.WIDTH(WIDTH)) u_drive (
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .perif_oe  (perif_oe),
        .perif_out (perif_out),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    assign irq_level = level_s;
    assign perif_in  = stop_mode ? '0 : level_s;
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_we,
    input logic [WIDTH-1:0] bus_wdata,
    input logic             bus_re,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] perif_oe,
    input logic [WIDTH-1:0] perif_out,
    input logic             stop_mode,
    input logic [WIDTH-1:0] perif_in,
    input logic [WIDTH-1:0] irq_level
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R3: an undriven pin carries a zero drive value
    p_undriven_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R7: override forces driver on with peripheral value
    p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((perif_oe & ~pad_oe) == '0) && ((perif_oe & (pad_out ^ perif_out)) == '0));

    // R4: a data write is visible on output pins not taken over
    p_latch_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=>
        ((pad_out & ~perif_oe) == ($past(bus_wdata) & pad_oe & ~perif_oe)));

    // R9: interrupt level trails the pad by two edges
    p_irq_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (irq_level == $past(pad_in, 2)));

    // R8: stop mode blocks peripheral input
    p_stop_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> (perif_in == '0));

    // R8: outside stop mode peripherals see the same level as interrupts
    p_stop_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |-> (perif_in == irq_level));

    // R10: idle read bus is zero
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));

    // R5: data read returns the synchronized level
    p_read_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 2'd0) |-> (bus_rdata == irq_level));
endmodule

bind gpx_port gpx_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_in    (pad_in),
    .perif_oe  (perif_oe),
    .perif_out (perif_out),
    .stop_mode (stop_mode),
    .perif_in  (perif_in),
    .irq_level (irq_level)
);

// File: tb/gpx_port_bench.sv
`timescale 1ns/1ps
module gpx_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_oe, pad_out, pad_in;
    logic [7:0] perif_oe = '0, perif_out = '0;
    logic       stop_mode = 1'b0;
    logic [7:0] perif_in, irq_level;
    logic [7:0] ext = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // pad model: driven pins show the drive value, others the external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpx_port u_gpx_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in),
        .perif_oe(perif_oe), .perif_out(perif_out), .stop_mode(stop_mode),
        .perif_in(perif_in), .irq_level(irq_level)
    );

    // fields: dir, latch, perif_oe, perif_out, ext, stop, exp_oe, exp_out
    localparam logic [63:0] VEC [6] = '{
        64'hFF_A5_00_00_3C_00_FF_A5,
        64'h00_5A_00_FF_C3_00_00_00,
        64'hF0_3C_00_00_99_FF_F0_30,
        64'h0F_FF_F0_A0_55_00_FF_AF,
        64'h00_00_81_01_7E_FF_81_01,
        64'hFF_00_FF_66_00_00_FF_66
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_re = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_re = 1'b0;
        #0.5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] lvl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        bus_read(2'd1, rd);
        chk("R1 dir read", rd, 8'h00);

        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            perif_oe  = VEC[v][47:40];
            perif_out = VEC[v][39:32];
            ext       = VEC[v][31:24];
            stop_mode = VEC[v][16];
            bus_write(2'd1, VEC[v][63:56]);
            bus_write(2'd0, VEC[v][55:48]);
            repeat (3) @(negedge clk);
            #1;
            lvl = (VEC[v][15:8] & VEC[v][7:0]) | (~VEC[v][15:8] & VEC[v][31:24]);
            chk("R2 R3 R7 pad_oe", pad_oe, VEC[v][15:8]);
            chk("R2 R3 R7 pad_out", pad_out, VEC[v][7:0]);
            bus_read(2'd0, rd);
            chk("R5 R7 data read", rd, lvl);
            bus_read(2'd1, rd);
            chk("R6 dir read", rd, VEC[v][63:56]);
            chk("R8 perif_in", perif_in, VEC[v][16] ? 8'h00 : lvl);
            chk("R9 irq_level", irq_level, lvl);
        end

        // R4: latch written while input, appears once output
        @(negedge clk);
        perif_oe = '0; stop_mode = 1'b0; ext = 8'h00;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h77);
        #1;
        chk("R4 hidden while input", pad_out, 8'h00);
        bus_write(2'd1, 8'hFF);
        #1;
        chk("R4 latch shown", pad_out, 8'h77);

        // R5: two-edge synchronizer delay on an input pin
        bus_write(2'd1, 8'h00);
        repeat (3) @(negedge clk);
        ext = 8'hC9;
        @(negedge clk);
        #1;
        bus_read(2'd0, rd);
        chk("R5 after one edge", rd, 8'h00);
        @(negedge clk);
        #1;
        bus_read(2'd0, rd);
        chk("R5 after two edges", rd, 8'hC9);
        // R9 live in stop mode with pins as inputs
        stop_mode = 1'b1;
        #1;
        chk("R9 stop irq", irq_level, 8'hC9);
        chk("R8 stop perif", perif_in, 8'h00);
        stop_mode = 1'b0;

        // R10: unused offsets
        bus_write(2'd1, 8'h3C);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'hFF);
        #1;
        bus_read(2'd1, rd);
        chk("R10 dir unchanged", rd, 8'h3C);
        chk("R10 pad_out unchanged", pad_out, 8'h34);
        bus_read(2'd3, rd);
        chk("R10 unused read", rd, 8'h00);
        bus_addr = 2'd1;
        #1;
        chk("R10 idle rdata", bus_rdata, 8'h00);

        finish_run();
    end
endmodule